// File: doc/BRIEF.md
# Block Checkpoint and Gated Store Buffer

This block lets a processor roll back to the state it had on entry to a translated code block. It holds a working register file and a shadow copy. Each store issued inside an open block is parked in a bounded buffer, and memory does not see it while the block is open.

A block-enter pulse closes the current block and opens the next one. On that pulse every working register is copied into the shadow set in one cycle, and the held stores become committed. Committed stores then leave for memory in issue order, one per cycle.

A trap pulse does the reverse. Every working register is reloaded from the shadow set, and every store not yet committed is thrown away. Stores that are already committed keep draining. A store that arrives while the buffer is full is refused, and an overflow flag goes high. The host treats that flag as a reason to trap.

Top module: `ckpt_store_buf`

## Requirements
- R1: After a synchronous active-low reset, all working and shadow registers read zero, the buffer is empty, `mem_we_o` is 0 and `sb_full_o` is 0.
- R2: A register write with `rf_we_i` updates the addressed working register at the clock edge. `rf_rdata_o` shows the working register at `rf_raddr_i` combinationally.
- R3: On a `blk_enter_i` cycle without a trap, all working registers, as they stood before that edge, are copied to the shadow set in one step. A register write in the same cycle lands only in the working set.
- R4: On a `trap_i` cycle, all working registers are reloaded from the shadow set at that edge. A register write in the same cycle is discarded.
- R5: A store accepted while a block is open never appears on the memory port before a later `blk_enter_i`.
- R6: After the `blk_enter_i` edge, the committed stores appear on the memory port starting the next cycle. They come one per cycle, with `mem_we_o`=1, in the order they were issued, and each carries its own address, data and 4-bit byte enable.
- R7: A trap discards every uncommitted store, including a store offered in the trap cycle. Those stores never reach the memory port.
- R8: The buffer holds 16 entries, counting committed stores not yet drained. `sb_full_o` is 1 exactly when 16 are held. A store offered while full is dropped, and `sb_overflow_o` is 1 in that same cycle.
- R9: When `trap_i` and `blk_enter_i` are both high, the trap wins. The shadow set is unchanged, the working set is restored, and the open block's stores are discarded.
- R10: Stores of a newly opened block queue behind committed stores that are still draining. A later trap removes only the new block's stores, and the committed ones still drain in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_enter_i | input | 1 | Commit the open block and take a checkpoint |
| trap_i | input | 1 | Roll back to the last checkpoint |
| rf_we_i | input | 1 | Working register write enable |
| rf_waddr_i | input | 5 | Write register index |
| rf_wdata_i | input | 32 | Write data |
| rf_raddr_i | input | 5 | Read register index |
| rf_rdata_o | output | 32 | Working register read data |
| st_valid_i | input | 1 | Store offered this cycle |
| st_addr_i | input | 32 | Store address |
| st_data_i | input | 32 | Store data |
| st_be_i | input | 4 | Store byte enables |
| mem_we_o | output | 1 | Memory write strobe for a committed store |
| mem_addr_o | output | 32 | Memory write address |
| mem_data_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory write byte enables |
| sb_full_o | output | 1 | Buffer holds 16 entries |
| sb_overflow_o | output | 1 | Store offered while full, dropped |

## Verification
Wrong internal state shows up at the ports quickly:
- A stale or partial shadow copy shows on the read port only after the next trap, so the bench reads back every register after each rollback.
- A misplaced commit boundary or head pointer shows within one cycle as a write strobe that is missing or extra, or as an address that does not match the expected store.
- A wrong occupancy count shows on the full flag the cycle the reference count reaches 16, or the cycle it drops below 16.

// File: rtl/ckpt_pkg.sv
// Package: shared types for the checkpoint and store buffer block.
// Assumes nothing beyond IEEE 1800-2017 packages.
package ckpt_pkg;

    // Action resolved for the current cycle from the block-enter and trap pulses
    typedef enum logic [1:0] {
        ACT_NONE     = 2'd0,
        ACT_COMMIT   = 2'd1,
        ACT_ROLLBACK = 2'd2
    } blk_act_e;

    // Trap takes priority over block entry
    function automatic blk_act_e resolve_act(input logic enter, input logic trap);
        if (trap)       return ACT_ROLLBACK;
        else if (enter) return ACT_COMMIT;
        else            return ACT_NONE;
    endfunction

endpackage

// File: rtl/ckpt_ctrl.sv
// Module: ckpt_ctrl
// Decodes the block-enter and trap pulses into one action per cycle.
// Assumes both pulses are synchronous to clk. Trap outranks block entry.
module ckpt_ctrl
    import ckpt_pkg::*;
(
    input  logic     enter_i,
    input  logic     trap_i,
    output blk_act_e act_o,
    output logic     commit_o,
    output logic     rollback_o
);

    // Pick the winning action and split it into strobes
    always_comb begin
        act_o      = resolve_act(enter_i, trap_i);
        commit_o   = (act_o == ACT_COMMIT);
        rollback_o = (act_o == ACT_ROLLBACK);
    end

endmodule

// File: rtl/ckpt_regfile.sv
// Module: ckpt_regfile
// Working register file with a full shadow copy.
// A checkpoint copies every working register into the shadow set in one cycle.
// A restore copies the shadow set back and drops any write in that cycle.
// Assumes ckpt_i and restore_i are never high together.
module ckpt_regfile #(
    parameter int NREGS = 32,
    parameter int XLEN  = 32,
    localparam int RIW  = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ckpt_i,
    input  logic            restore_i,
    input  logic            we_i,
    input  logic [RIW-1:0]  waddr_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic [RIW-1:0]  raddr_i,
    output logic [XLEN-1:0] rdata_o
);

    logic [NREGS-1:0][XLEN-1:0] work_q;
    logic [NREGS-1:0][XLEN-1:0] shad_q;

    genvar g;
    generate
        for (g = 0; g < NREGS; g++) begin : g_reg
            logic hit;
            // Decode whether this register is the write target
            always_comb hit = we_i && (waddr_i == RIW'(g));

            // Working register: restore beats write
            always_ff @(posedge clk) begin
                if (!rst_n)         work_q[g] <= '0;
                else if (restore_i) work_q[g] <= shad_q[g];
                else if (hit)       work_q[g] <= wdata_i;
            end

            // Shadow register: captures pre-edge working value on checkpoint
            always_ff @(posedge clk) begin
                if (!rst_n)      shad_q[g] <= '0;
                else if (ckpt_i) shad_q[g] <= work_q[g];
            end
        end
    endgenerate

    // Combinational read of the working set
    always_comb rdata_o = work_q[raddr_i];

    AST_CKPT_COPY:   assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_i |=> (shad_q == $past(work_q)));                         // R3
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ckpt_i |=> $stable(shad_q));                                  // R9
    AST_RESTORE:     assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> (work_q == $past(shad_q)));                      // R4

endmodule

// File: rtl/ckpt_store_queue.sv
// Module: ckpt_store_queue
// Circular store buffer with three pointers: head (next to drain),
// commit boundary and tail. Entries between head and the commit boundary
// drain one per cycle. Entries between the boundary and tail belong to the
// open block.
// Assumes commit_i and discard_i are never high together.
module ckpt_store_queue #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int BW    = 4,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enq_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] data_i,
    input  logic [BW-1:0] be_i,
    input  logic          commit_i,
    input  logic          discard_i,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_data_o,
    output logic [BW-1:0] mem_be_o,
    output logic          full_o
);

    logic [AW-1:0] addr_mem [DEPTH];
    logic [DW-1:0] data_mem [DEPTH];
    logic [BW-1:0] be_mem   [DEPTH];

    logic [PW:0] head_q, cmt_q, tail_q;
    logic [PW:0] used;
    logic        enq_ok;

    // Occupancy and acceptance of an offered store
    always_comb begin
        used     = tail_q - head_q;
        full_o   = (used == (PW+1)'(DEPTH));
        enq_ok   = enq_i && !full_o && !discard_i;
        mem_we_o = (head_q != cmt_q);
    end

    // Present the oldest committed entry to memory
    always_comb begin
        mem_addr_o = addr_mem[head_q[PW-1:0]];
        mem_data_o = data_mem[head_q[PW-1:0]];
        mem_be_o   = be_mem[head_q[PW-1:0]];
    end

    // Write an accepted store into its slot
    always_ff @(posedge clk) begin
        if (enq_ok) begin
            addr_mem[tail_q[PW-1:0]] <= addr_i;
            data_mem[tail_q[PW-1:0]] <= data_i;
            be_mem[tail_q[PW-1:0]]   <= be_i;
        end
    end

    // Head pointer: advances once per drained store
    always_ff @(posedge clk) begin
        if (!rst_n)        head_q <= '0;
        else if (mem_we_o) head_q <= head_q + 1'b1;
    end

    // Commit boundary: seals everything queued so far
    always_ff @(posedge clk) begin
        if (!rst_n)                    cmt_q <= '0;
        else if (commit_i && !discard_i) cmt_q <= tail_q;
    end

    // Tail pointer: rewinds on discard, advances on accepted store
    always_ff @(posedge clk) begin
        if (!rst_n)         tail_q <= '0;
        else if (discard_i) tail_q <= cmt_q;
        else if (enq_ok)    tail_q <= tail_q + 1'b1;
    end

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n)
        used <= (PW+1)'(DEPTH));                                       // R8
    AST_FULL_BLOCKS:  assert property (@(posedge clk) disable iff (!rst_n)
        full_o |=> (tail_q != $past(tail_q) + 1'b1));                  // R8
    AST_KEEP_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
        discard_i |=> ((cmt_q - head_q) ==
                       ($past(cmt_q) - $past(head_q) - (PW+1)'($past(mem_we_o))))); // R10
    AST_DISCARD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        discard_i |=> (tail_q == cmt_q));                              // R7

endmodule

// File: rtl/ckpt_store_buf.sv
// Module: ckpt_store_buf (top)
// Block-level checkpointing: a shadowed register file plus a gated store
// buffer. Block entry commits and checkpoints; a trap rolls back. Trap wins
// over a block entry in the same cycle.
// Assumes a single clock domain and that the memory accepts one write per cycle.
module ckpt_store_buf #(
    parameter int NREGS    = 32,
    parameter int XLEN     = 32,
    parameter int AW       = 32,
    parameter int BW       = XLEN / 8,
    parameter int SB_DEPTH = 16,
    localparam int RIW     = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            blk_enter_i,
    input  logic            trap_i,
    input  logic            rf_we_i,
    input  logic [RIW-1:0]  rf_waddr_i,
    input  logic [XLEN-1:0] rf_wdata_i,
    input  logic [RIW-1:0]  rf_raddr_i,
    output logic [XLEN-1:0] rf_rdata_o,
    input  logic            st_valid_i,
    input  logic [AW-1:0]   st_addr_i,
    input  logic [XLEN-1:0] st_data_i,
    input  logic [BW-1:0]   st_be_i,
    output logic            mem_we_o,
    output logic [AW-1:0]   mem_addr_o,
    output logic [XLEN-1:0] mem_data_o,
    output logic [BW-1:0]   mem_be_o,
    output logic            sb_full_o,
    output logic            sb_overflow_o
);

    import ckpt_pkg::*;

    blk_act_e act;
    logic     do_commit, do_rollback;

    ckpt_ctrl u_ctrl (
        .enter_i    (blk_enter_i),
        .trap_i     (trap_i),
        .act_o      (act),
        .commit_o   (do_commit),
        .rollback_o (do_rollback)
    );

    ckpt_regfile #(.NREGS(NREGS), .XLEN(XLEN)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ckpt_i    (do_commit),
        .restore_i (do_rollback),
        .we_i      (rf_we_i),
        .waddr_i   (rf_waddr_i),
        .wdata_i   (rf_wdata_i),
        .raddr_i   (rf_raddr_i),
        .rdata_o   (rf_rdata_o)
    );

    ckpt_store_queue #(.DEPTH(SB_DEPTH), .AW(AW), .DW(XLEN), .BW(BW)) u_sq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enq_i      (st_valid_i),
        .addr_i     (st_addr_i),
        .data_i     (st_data_i),
        .be_i       (st_be_i),
        .commit_i   (do_commit),
        .discard_i  (do_rollback),
        .mem_we_o   (mem_we_o),
        .mem_addr_o (mem_addr_o),
        .mem_data_o (mem_data_o),
        .mem_be_o   (mem_be_o),
        .full_o     (sb_full_o)
    );

    // Flag a store refused for lack of room
    always_comb sb_overflow_o = st_valid_i && sb_full_o;

    AST_TRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_enter_i && trap_i) |-> (act == ACT_ROLLBACK));           // R9
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_commit, do_rollback}));                          // R9

endmodule

// File: tb/ckpt_store_buf_tb_top.sv
module ckpt_store_buf_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        blk_enter_i, trap_i, rf_we_i, st_valid_i;
    logic [4:0]  rf_waddr_i, rf_raddr_i;
    logic [31:0] rf_wdata_i, rf_rdata_o, st_addr_i, st_data_i;
    logic [3:0]  st_be_i, mem_be_o;
    logic        mem_we_o, sb_full_o, sb_overflow_o;
    logic [31:0] mem_addr_o, mem_data_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    ckpt_store_buf dut_i (
        .clk(clk), .rst_n(rst_n), .blk_enter_i(blk_enter_i), .trap_i(trap_i),
        .rf_we_i(rf_we_i), .rf_waddr_i(rf_waddr_i), .rf_wdata_i(rf_wdata_i),
        .rf_raddr_i(rf_raddr_i), .rf_rdata_o(rf_rdata_o),
        .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_data_i(st_data_i),
        .st_be_i(st_be_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_data_o(mem_data_o), .mem_be_o(mem_be_o),
        .sb_full_o(sb_full_o), .sb_overflow_o(sb_overflow_o)
    );

    typedef struct { logic [31:0] a; logic [31:0] d; logic [3:0] b; } ent_t;

    logic [31:0] m_wk [32];
    logic [31:0] m_sh [32];
    ent_t        m_q [$];
    int          m_ncmt;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 0;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle: drive inputs, compare outputs against the model, advance the model
    task automatic step(string tag, bit ent, bit trp, bit we, int wa, logic [31:0] wd,
                        int ra, bit sv, logic [31:0] sa, logic [31:0] sd, logic [3:0] sb);
        bit full_pre;
        @(negedge clk);
        blk_enter_i = ent; trap_i = trp; rf_we_i = we;
        rf_waddr_i = 5'(wa); rf_wdata_i = wd; rf_raddr_i = 5'(ra);
        st_valid_i = sv; st_addr_i = sa; st_data_i = sd; st_be_i = sb;
        #1;
        full_pre = (m_q.size() == DEPTH);
        chk(tag, "rdata", rf_rdata_o, m_wk[ra]);
        chk(tag, "mem_we", 32'(mem_we_o), 32'(m_ncmt > 0));
        if (m_ncmt > 0) begin
            chk(tag, "mem_addr", mem_addr_o, m_q[0].a);
            chk(tag, "mem_data", mem_data_o, m_q[0].d);
            chk(tag, "mem_be", 32'(mem_be_o), 32'(m_q[0].b));
        end
        chk(tag, "full", 32'(sb_full_o), 32'(full_pre));
        chk(tag, "overflow", 32'(sb_overflow_o), 32'(sv && full_pre));
        @(posedge clk);
        if (m_ncmt > 0) begin
            void'(m_q.pop_front());
            m_ncmt--;
        end
        if (trp) begin
            for (int i = 0; i < 32; i++) m_wk[i] = m_sh[i];
            while (m_q.size() > m_ncmt) void'(m_q.pop_back());
        end else begin
            if (ent) begin
                for (int i = 0; i < 32; i++) m_sh[i] = m_wk[i];
                m_ncmt = m_q.size();
            end
            if (we) m_wk[wa] = wd;
            if (sv && !full_pre) begin
                ent_t e;
                e.a = sa; e.d = sd; e.b = sb;
                m_q.push_back(e);
            end
        end
    endtask

    task automatic idle(string tag, int ra);
        step(tag, 0, 0, 0, 0, 0, ra, 0, 0, 0, 0);
    endtask

    task automatic store(string tag, logic [31:0] a, logic [31:0] d, logic [3:0] b);
        step(tag, 0, 0, 0, 0, 0, 0, 1, a, d, b);
    endtask

    task automatic read_all(string tag);
        for (int i = 0; i < 32; i++) idle(tag, i);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                n_errors++;
                $display("FAIL watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
                summary();
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_wk[i] = 0; m_sh[i] = 0; end
        m_ncmt = 0;
        rst_n = 0; blk_enter_i = 0; trap_i = 0; rf_we_i = 0; st_valid_i = 0;
        rf_waddr_i = 0; rf_raddr_i = 0; rf_wdata_i = 0;
        st_addr_i = 0; st_data_i = 0; st_be_i = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state
        read_all("R1");

        // R2: write every register, read back
        for (int i = 0; i < 32; i++) step("R2", 0, 0, 1, i, 32'hA000_0000 + i * 7, i, 0, 0, 0, 0);
        read_all("R2");

        // R3: checkpoint with a same-cycle write, then scribble and trap (R4)
        step("R3", 1, 0, 1, 3, 32'h3333_0003, 3, 0, 0, 0, 0);
        for (int i = 0; i < 32; i += 3) step("R3", 0, 0, 1, i, 32'hDEAD_0000 + i, i, 0, 0, 0, 0);
        step("R4", 0, 1, 1, 5, 32'hBAD0_0005, 5, 0, 0, 0, 0);
        read_all("R4");

        // R5/R6: stores held until entry, then drain in order
        store("R5", 32'h100, 32'h11, 4'h1);
        store("R5", 32'h104, 32'h22, 4'h3);
        store("R5", 32'h108, 32'h33, 4'hF);
        repeat (4) idle("R5", 0);
        step("R6", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (5) idle("R6", 0);

        // R7: trap discards open stores, including one in the trap cycle
        store("R7", 32'h200, 32'h44, 4'h2);
        store("R7", 32'h204, 32'h55, 4'h4);
        step("R7", 0, 1, 0, 0, 0, 0, 1, 32'h208, 32'h66, 4'h8);
        step("R7", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) idle("R7", 0);

        // R8: fill to capacity and overflow
        for (int i = 0; i < DEPTH + 3; i++) store("R8", 32'h300 + 4 * i, 32'h800 + i, 4'(i));
        step("R8", 1, 0, 0, 0, 0, 0, 1, 32'h3FC, 32'h999, 4'h5);
        repeat (DEPTH + 2) idle("R8", 0);

        // R9: trap and entry together
        step("R9", 0, 0, 1, 9, 32'h9999_0009, 9, 1, 32'h400, 32'h77, 4'h1);
        step("R9", 1, 1, 0, 0, 0, 9, 0, 0, 0, 0);
        repeat (3) idle("R9", 9);
        read_all("R9");

        // R10: new block's stores behind draining ones, then trap
        for (int i = 0; i < 5; i++) store("R10", 32'h500 + 4 * i, 32'hA0 + i, 4'hF);
        step("R10", 1, 0, 0, 0, 0, 0, 1, 32'h600, 32'hB0, 4'h1);
        store("R10", 32'h604, 32'hB1, 4'h2);
        store("R10", 32'h608, 32'hB2, 4'h4);
        step("R10", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (6) idle("R10", 0);

        // Mixed traffic across all rules
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 99));
            step("R6", r < 6, r >= 96, $urandom_range(0, 2) == 0,
                 int'($urandom_range(0, 31)), $urandom, int'($urandom_range(0, 31)),
                 $urandom_range(0, 1) == 1, $urandom, $urandom, 4'($urandom));
        end
        step("R10", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (DEPTH + 2) idle("R6", 0);

        done = 1;
        summary();
        $finish;
    end

endmodule